// File: doc/BRIEF.md
# DDC Display-ID Fetcher

This block pulls the 128-byte identification record out of a monitor over a two-wire serial bus. It drives the bus by toggling bits in a general-purpose output word and reads it back from a general-purpose input word. A bit set to 1 in the output word pulls its line low. A bit set to 0 leaves the line to its pull-up. Each of the two attached display ports has its own clock-out, data-out and data-in bit positions, given as parameters. A port may also have an enable bit, which is then set in every word written while that port is selected.

A one-cycle `start` pulse runs one fixed read transaction on port 0. The transaction is a start condition, the read address byte, then 128 received bytes, each acknowledged by this block, then a stop condition. The received bytes land in an internal buffer. The header is valid when byte 0 is 0x00 and byte 1 is 0xFF. If the port 0 header is not valid, the whole transaction is repeated on port 1. When the last attempt ends, `done` pulses for one cycle. At that point `valid` and `good_port` report the result, and the buffer can be read through a synchronous byte port. Every level on the bus is held for `STEP_CYCLES` clock cycles, and this sets the bus rate.

Top module: `edid_fetch`

## Requirements
- R1: While and right after reset, `done` and `valid` are 0 and `pin_word` is all zeros (port 0 has no enable bit), so both lines are released.
- R2: Each attempt opens with the pattern (clock,data) = high/high, high/low, low/low and closes with low/low, high/low, high/high. So each attempt yields exactly one start condition and one stop condition on the selected port.
- R3: The first byte sent is 0xA1 (device address 0x50 with the read bit set), most significant bit first. Data stays constant over a low, high, low clock cycle. A clock pulse with data driven low by this block follows it.
- R4: 128 bytes are received most significant bit first. During each bit the block releases data and samples the data-in bit at the end of the clock-high step. Received byte k is stored at buffer index k. `rd_data` shows the byte at `rd_addr` one clock after the address is applied.
- R5: This block acknowledges every received byte, the last one included, by holding data low across one clock pulse. That gives 129 low-data acknowledge pulses per attempt.
- R6: An output bit of 1 means the line is low. Port 0 uses clock-out bit 17, data-out bit 16, data-in bit 8 and no enable. Port 1 uses clock-out bit 18, data-out bit 17, data-in bit 9 and enable bit 25. While `pin_port` is 1, bit 25 of `pin_word` is always 1. No bit outside the selected port's set is ever 1.
- R7: `valid` is 1 after an attempt only if that attempt read byte 0 = 0x00 and byte 1 = 0xFF. `valid` becomes 1 only in the cycle `done` pulses.
- R8: If port 0's header is invalid, the transaction is repeated on port 1. After the last attempt, `good_port` is the port read last. That is 0 when port 0 succeeds, and otherwise 1, with the buffer holding port 1's data.
- R9: `done` is a single-cycle pulse after the final attempt. `valid` is cleared within two cycles of `start`.
- R10: Inside a transaction, every clock-high phase lasts exactly `STEP_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to fetch the record; ignored while a fetch runs |
| pin_in | input | WORD_W | General-purpose input word; the selected port's data-in bit carries the data line level |
| pin_word | output | WORD_W | Registered general-purpose output word; 1 pulls a line low |
| pin_port | output | 1 | Port whose bit mapping `pin_word` uses (0 or 1) |
| done | output | 1 | One-cycle pulse at the end of the last attempt |
| valid | output | 1 | Header of the last read record was valid |
| good_port | output | 1 | Port that was read last |
| rd_addr | input | AW | Buffer byte index to read |
| rd_data | output | 8 | Buffer byte, one cycle after `rd_addr` |

## Verification
An attempt takes about 3500 bus steps. `done` is therefore awaited in a bounded loop, and `valid` and `good_port` are checked on the same cycle as the `done` pulse, because all three come from the same register stage. The single-pulse property is then checked one cycle later. The bench models the display as a wired-AND slave that watches the registered output word on the falling clock edge. It changes data only after it has seen a clock fall, so the block's sample at the end of the high step always meets settled data. Buffer reads apply an address and compare one clock later, which matches the one-register read path.

// File: rtl/edid_pkg.sv
package edid_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_AACK,
    PH_RECV,
    PH_RACK,
    PH_STOP
  } phase_t;

  localparam logic [7:0] HDR_BYTE0 = 8'h00;
  localparam logic [7:0] HDR_BYTE1 = 8'hFF;

  function automatic logic [7:0] read_cmd(input logic [6:0] dev);
    return {dev, 1'b1};
  endfunction

endpackage

// File: rtl/edid_blob_ram.sv
module edid_blob_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/edid_pin_map.sv
// Turns the wanted line levels into one port's output word (1 = pull low).
module edid_pin_map #(
  parameter int WORD_W  = 32,
  parameter int SCL_POS = 17,
  parameter int SDA_POS = 16,
  parameter int EN_POS  = -1
) (
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] en_mask;

  generate
    if (EN_POS >= 0) begin : g_en
      assign en_mask = WORD_W'(1) << EN_POS;
    end else begin : g_no_en
      assign en_mask = '0;
    end
  endgenerate

  assign word = en_mask
              | (WORD_W'(!scl_lvl) << SCL_POS)
              | (WORD_W'(!sda_lvl) << SDA_POS);
endmodule

// File: rtl/edid_bus_seq.sv
// Step sequencer for one fixed read transaction.
module edid_bus_seq
  import edid_pkg::*;
#(
  parameter int         STEP_CYCLES = 125,
  parameter int         BLOB_BYTES  = 128,
  parameter int         AW          = 7,
  parameter logic [7:0] ADDR_BYTE   = 8'hA1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          sda_in,
  output logic          scl_lvl,
  output logic          sda_lvl,
  output logic          fin,
  output logic          byte_we,
  output logic [AW-1:0] byte_idx,
  output logic [7:0]    byte_val
);
  localparam int TW = $clog2(STEP_CYCLES + 1);

  phase_t        phase;
  logic [TW-1:0] tmr;
  logic [1:0]    step;
  logic [2:0]    bitn;
  logic [7:0]    shreg;

  wire tick      = (phase != PH_IDLE) && (tmr == TW'(STEP_CYCLES - 1));
  wire last_step = (step == 2'd2);
  wire mid_step  = (step == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      tmr      <= '0;
      step     <= '0;
      bitn     <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      byte_val <= '0;
      byte_we  <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin     <= 1'b0;
      byte_we <= 1'b0;
      if (phase == PH_IDLE) begin
        if (go) begin
          phase <= PH_START;
          tmr   <= '0;
          step  <= '0;
        end
      end else if (!tick) begin
        tmr <= tmr + TW'(1);
      end else begin
        tmr <= '0;
        if (phase == PH_RECV && mid_step) shreg <= {shreg[6:0], sda_in};
        if (!last_step) begin
          step <= step + 2'd1;
        end else begin
          step <= 2'd0;
          case (phase)
            PH_START: begin
              phase <= PH_ADDR;
              bitn  <= '0;
            end
            PH_ADDR: begin
              if (bitn == 3'd7) phase <= PH_AACK;
              else              bitn  <= bitn + 3'd1;
            end
            PH_AACK: begin
              phase    <= PH_RECV;
              bitn     <= '0;
              byte_idx <= '0;
            end
            PH_RECV: begin
              if (bitn == 3'd7) begin
                phase    <= PH_RACK;
                byte_we  <= 1'b1;
                byte_val <= shreg;
              end else begin
                bitn <= bitn + 3'd1;
              end
            end
            PH_RACK: begin
              if (byte_idx == AW'(BLOB_BYTES - 1)) begin
                phase <= PH_STOP;
              end else begin
                byte_idx <= byte_idx + AW'(1);
                bitn     <= '0;
                phase    <= PH_RECV;
              end
            end
            PH_STOP: begin
              phase <= PH_IDLE;
              fin   <= 1'b1;
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_lvl = 1'b1;
    sda_lvl = 1'b1;
    case (phase)
      PH_START: begin
        scl_lvl = (step != 2'd2);
        sda_lvl = (step == 2'd0);
      end
      PH_ADDR: begin
        scl_lvl = mid_step;
        sda_lvl = ADDR_BYTE[3'd7 - bitn];
      end
      PH_AACK, PH_RACK: begin
        scl_lvl = mid_step;
        sda_lvl = 1'b0;
      end
      PH_RECV: begin
        scl_lvl = mid_step;
        sda_lvl = 1'b1;
      end
      PH_STOP: begin
        scl_lvl = (step != 2'd0);
        sda_lvl = (step == 2'd2);
      end
      default: begin
        scl_lvl = 1'b1;
        sda_lvl = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
  import edid_pkg::*;
#(
  parameter int         WORD_W      = 32,
  parameter int         STEP_CYCLES = 125,
  parameter int         BLOB_BYTES  = 128,
  parameter int         AW          = $clog2(BLOB_BYTES),
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         P0_SCL      = 17,
  parameter int         P0_SDA      = 16,
  parameter int         P0_DIN      = 8,
  parameter int         P0_EN       = -1,
  parameter int         P1_SCL      = 18,
  parameter int         P1_SDA      = 17,
  parameter int         P1_DIN      = 9,
  parameter int         P1_EN       = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] pin_in,
  output logic [WORD_W-1:0] pin_word,
  output logic              pin_port,
  output logic              done,
  output logic              valid,
  output logic              good_port,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data
);
  logic              go, port, running, hdr0_ok, hdr1_ok;
  logic              scl_lvl, sda_lvl, fin, byte_we;
  logic [AW-1:0]     byte_idx;
  logic [7:0]        byte_val;
  logic [WORD_W-1:0] word0, word1;

  wire sda_in = port ? pin_in[P1_DIN] : pin_in[P0_DIN];
  wire hdr_ok = hdr0_ok && hdr1_ok;

  edid_bus_seq #(
    .STEP_CYCLES(STEP_CYCLES),
    .BLOB_BYTES (BLOB_BYTES),
    .AW         (AW),
    .ADDR_BYTE  (read_cmd(DEV_ADDR))
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .sda_in  (sda_in),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .fin     (fin),
    .byte_we (byte_we),
    .byte_idx(byte_idx),
    .byte_val(byte_val)
  );

  edid_pin_map #(
    .WORD_W(WORD_W), .SCL_POS(P0_SCL), .SDA_POS(P0_SDA), .EN_POS(P0_EN)
  ) u_map0 (
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .word(word0)
  );

  edid_pin_map #(
    .WORD_W(WORD_W), .SCL_POS(P1_SCL), .SDA_POS(P1_SDA), .EN_POS(P1_EN)
  ) u_map1 (
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .word(word1)
  );

  edid_blob_ram #(
    .DEPTH(BLOB_BYTES), .AW(AW)
  ) u_ram (
    .clk  (clk),
    .we   (byte_we),
    .waddr(byte_idx),
    .wdata(byte_val),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      go        <= 1'b0;
      port      <= 1'b0;
      running   <= 1'b0;
      hdr0_ok   <= 1'b0;
      hdr1_ok   <= 1'b0;
      valid     <= 1'b0;
      done      <= 1'b0;
      good_port <= 1'b0;
      pin_word  <= '0;
      pin_port  <= 1'b0;
    end else begin
      go       <= 1'b0;
      done     <= 1'b0;
      pin_word <= port ? word1 : word0;
      pin_port <= port;

      if (start && !running) begin
        running <= 1'b1;
        port    <= 1'b0;
        go      <= 1'b1;
        valid   <= 1'b0;
        hdr0_ok <= 1'b0;
        hdr1_ok <= 1'b0;
      end

      if (byte_we && byte_idx == AW'(0)) hdr0_ok <= (byte_val == HDR_BYTE0);
      if (byte_we && byte_idx == AW'(1)) hdr1_ok <= (byte_val == HDR_BYTE1);

      if (fin) begin
        if (hdr_ok || port) begin
          done      <= 1'b1;
          valid     <= hdr_ok;
          good_port <= port;
          running   <= 1'b0;
        end else begin
          port    <= 1'b1;
          go      <= 1'b1;
          hdr0_ok <= 1'b0;
          hdr1_ok <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk #(
  parameter int WORD_W      = 32,
  parameter int STEP_CYCLES = 125,
  parameter int P0_SCL      = 17,
  parameter int P0_SDA      = 16,
  parameter int P0_EN       = -1,
  parameter int P1_SCL      = 18,
  parameter int P1_SDA      = 17,
  parameter int P1_EN       = 25
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] pin_word,
  input logic              pin_port,
  input logic              done,
  input logic              valid
);
  localparam int CW = $clog2(STEP_CYCLES + 1) + 1;

  function automatic logic [WORD_W-1:0] bitm(input int p);
    return (p >= 0) ? (WORD_W'(1) << p) : '0;
  endfunction

  localparam logic [WORD_W-1:0] MASK0 = bitm(P0_SCL) | bitm(P0_SDA) | bitm(P0_EN);
  localparam logic [WORD_W-1:0] MASK1 = bitm(P1_SCL) | bitm(P1_SDA) | bitm(P1_EN);

  wire scl_hi = pin_port ? !pin_word[P1_SCL] : !pin_word[P0_SCL];

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                          hi_cnt <= '0;
    else if (!scl_hi)                 hi_cnt <= '0;
    else if (hi_cnt != CW'(STEP_CYCLES)) hi_cnt <= hi_cnt + CW'(1);
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> done);

  assert_no_stray_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_word & ~(pin_port ? MASK1 : MASK0)) == '0);

  assert_scl_high_width_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_hi) |-> (hi_cnt == CW'(STEP_CYCLES)));

  generate
    if (P1_EN >= 0) begin : g_en_chk
      assert_enable_held_R6: assert property (@(posedge clk) disable iff (rst)
        pin_port |-> pin_word[P1_EN]);
    end
  endgenerate
endmodule

bind edid_fetch edid_fetch_chk #(
  .WORD_W(WORD_W), .STEP_CYCLES(STEP_CYCLES),
  .P0_SCL(P0_SCL), .P0_SDA(P0_SDA), .P0_EN(P0_EN),
  .P1_SCL(P1_SCL), .P1_SDA(P1_SDA), .P1_EN(P1_EN)
) u_chk (
  .clk(clk), .rst(rst), .pin_word(pin_word), .pin_port(pin_port),
  .done(done), .valid(valid)
);

// File: tb/edid_fetch_tb.sv
module edid_fetch_tb;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] pin_in;
  logic [31:0] pin_word;
  logic        pin_port, done, valid, good_port;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  edid_fetch #(.STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pin_in(pin_in),
    .pin_word(pin_word), .pin_port(pin_port), .done(done), .valid(valid),
    .good_port(good_port), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // display model: wired-AND data line, bit positions per R6
  logic [7:0] mem0 [128];
  logic [7:0] mem1 [128];
  wire  line_scl = ~(pin_port ? pin_word[18] : pin_word[17]);
  logic slave_sda;
  wire  line_sda = ~(pin_port ? pin_word[17] : pin_word[16]) & slave_sda;
  assign pin_in = pin_port ? (32'(line_sda) << 9) : (32'(line_sda) << 8);

  bit   active = 0;
  int   falls = 0, rises = 0, starts = 0, stops = 0, acks = 0;
  int   hi_w = 0, width_errs = 0, en_errs = 0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  logic [7:0] addr_sh = '0;
  int   q_i, b_i, j_i;

  always_comb begin
    slave_sda = 1'b1;
    q_i = falls - 10;
    b_i = q_i / 9;
    j_i = q_i % 9;
    if (active && falls >= 10 && j_i < 8 && b_i < 128)
      slave_sda = pin_port ? mem1[b_i][7-j_i] : mem0[b_i][7-j_i];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pin_port && !pin_word[25]) en_errs++;
      if (line_scl && scl_p && sda_p && !line_sda) begin
        active = 1; falls = 0; rises = 0; starts++;
      end else if (line_scl && scl_p && !sda_p && line_sda) begin
        active = 0; stops++;
      end
      if (scl_p && !line_scl) begin
        if (rises > 0 && hi_w != STEP) width_errs++;
        falls++;
      end
      if (!scl_p && line_scl) begin
        if (rises < 8) addr_sh = {addr_sh[6:0], line_sda};
        else if (rises == 8 && !line_sda) acks++;
        else if (rises > 8 && (rises - 9) % 9 == 8 && !line_sda) acks++;
        rises++;
        hi_w = 0;
      end
      if (line_scl) hi_w++;
      scl_p = line_scl;
      sda_p = line_sda;
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < 128; i++) begin
      mem0[i] = 8'((i * 29 + seed * 7) ^ (i >> 2));
      mem1[i] = 8'(i * 53 + seed * 11 + 3);
    end
    mem0[0] = 8'h00; mem0[1] = 8'hFF;
    mem1[0] = 8'h00; mem1[1] = 8'hFF;
  endtask

  task automatic run_case(input string nm);
    bit ok0, ok1, exp_valid, exp_port;
    int att, s0, t0, a0, cyc;
    ok0 = (mem0[0] == 8'h00) && (mem0[1] == 8'hFF);
    ok1 = (mem1[0] == 8'h00) && (mem1[1] == 8'hFF);
    exp_valid = ok0 || ok1;
    exp_port  = !ok0;
    att = ok0 ? 1 : 2;
    s0 = starts; t0 = stops; a0 = acks;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, {nm, " R9 valid cleared at start"}, valid, 0);
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, {nm, " R9 done arrives"}, done, 1);
    check(valid == exp_valid, {nm, " R7 header verdict"}, valid, exp_valid);
    check(good_port == exp_port, {nm, " R8 port read last"}, good_port, exp_port);
    @(negedge clk);
    check(done == 1'b0, {nm, " R9 done single pulse"}, done, 0);
    check(starts - s0 == att, {nm, " R2 start conditions"}, starts - s0, att);
    check(stops - t0 == att, {nm, " R2 stop conditions"}, stops - t0, att);
    check(acks - a0 == 129 * att, {nm, " R3 R5 acknowledge pulses"}, acks - a0, 129 * att);
    check(addr_sh == 8'hA1, {nm, " R3 address byte"}, addr_sh, 8'hA1);
    for (int i = 0; i < 128; i++) begin
      rd_addr = 7'(i);
      @(negedge clk);
      check(rd_data == (exp_port ? mem1[i] : mem0[i]), {nm, " R4 buffer byte"},
            rd_data, exp_port ? mem1[i] : mem0[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(valid == 1'b0, "R1 valid in reset", valid, 0);
    check(pin_word == 32'h0, "R1 word in reset", pin_word, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(pin_word == 32'h0, "R1 idle word released", pin_word, 0);

    fill(1);
    run_case("port0 good");

    fill(2);
    mem1[0] = 8'h12; mem1[1] = 8'h34;
    run_case("port0 good, port1 garbage");

    fill(3);
    mem0[1] = 8'hFE;
    run_case("port0 header byte1 off, fallback");

    fill(4);
    mem0[0] = 8'h01;
    for (int i = 0; i < 128; i++) mem1[i] = 8'hFF;
    run_case("both invalid");

    fill(5);
    mem0[0] = 8'hFF; mem0[1] = 8'h00;
    run_case("port0 header swapped, fallback");

    fill(6);
    run_case("port0 good after failure");

    check(en_errs == 0, "R6 enable bit held on port 1", en_errs, 0);
    check(width_errs == 0, "R10 clock-high width", width_errs, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule